// File: doc/BRIEF.md
# Guarded System Clock Prescaler

This block produces a clock-enable pulse for downstream logic. The enable fires once every N cycles of the input clock, where N is a power of two from 1 to 256. A 4-bit select value held in one 8-bit control register chooses N. Logic that runs on the divided rate qualifies its registers with the enable and does not use a second clock.

The select value is protected against stray writes. Software first writes an unlock word, which opens a short acceptance window. Only a select write that lands inside that window changes the rate. A static configuration input acts like a nonvolatile option bit and decides whether the block comes out of reset at full speed or divided by 8. A new rate takes effect only when the current count period finishes, so the enable never produces a shortened period.

Top module: `sysclk_prescale_guard`

## Requirements
- R1: While `rst` is high the register resets. Afterwards `rd_data` reads 0x03 and the enable period is 8 if `boot_slow` was 1, or reads 0x00 with the enable held high if `boot_slow` was 0.
- R2: A write of exactly 0x80 sets the unlock flag (read back on bit 7) and leaves the select value unchanged. A write with bit 7 set and any other bit set is ignored and does not open the window.
- R3: After the unlock write at clock edge t, a select write (bit 7 clear) is accepted at edges t+1 through t+4. At edge t+5 the window has closed: the write is ignored and bit 7 reads 0.
- R4: A select write made while the window is closed leaves the register unchanged.
- R5: Codes 9 to 15 are reserved. A write of a reserved code inside the window is ignored, the previous select value stays, and the window closes.
- R6: A select write with code 0 to 8 inside the window loads the code into bits 3:0 and clears bit 7, whatever the value of `boot_slow`.
- R7: For code k (0..8), `clk_en` is a single-cycle pulse once every 2^k input clocks. For code 0 it stays high.
- R8: A new code takes effect only at the end of the current count period. Every interval between consecutive enable pulses therefore equals either the old factor or the new factor, and is always a power of two no larger than 256.
- R9: Readback is {unlock flag, 000, select code}. Bits 6:4 of a written select value are ignored.
- R10: An unlock write made while the window is already open restarts the four-cycle window from that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| boot_slow | input | 1 | Static option: 1 selects divide-by-8 at reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| rd_data | output | 8 | Register readback |
| clk_en | output | 1 | Divided clock-enable pulse |

## Verification
Directed sequences place the select write on each side of the window edge: on the fourth cycle after unlocking and on the fifth. They also cover a restarted window, a malformed unlock word, and a reserved code, so that an off-by-one window and a missing reserved-code filter each show up as a wrong readback. A sweep over all nine legal codes measures the steady pulse spacing, which exposes a wrong limit table. Long runs of random unlock, select and idle traffic then exercise both the register model and a monitor that checks every pulse interval. A rate change applied in the middle of a period would produce an interval that is not a power of two, and the monitor would catch it.

// File: rtl/scp_pkg.sv
package scp_pkg;
  localparam int SEL_W = 4;
  typedef logic [SEL_W-1:0] sel_t;
  localparam sel_t SLOW_BOOT_CODE = 4'd3;

  function automatic sel_t boot_code(input logic slow);
    return slow ? SLOW_BOOT_CODE : sel_t'(0);
  endfunction
endpackage

// File: rtl/scp_unlock.sv
module scp_unlock
  import scp_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int WIN      = 4,
  parameter int MAX_CODE = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              boot_slow,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              arm_o,
  output sel_t              sel_o
);
  localparam int ARM_BIT = DATA_W - 1;
  localparam int WC_W = $clog2(WIN + 1);
  localparam logic [DATA_W-1:0] ARM_WORD = DATA_W'(1) << ARM_BIT;
  localparam sel_t TOP_CODE = SEL_W'(MAX_CODE);

  logic            arm_q;
  logic [WC_W-1:0] win_q;
  sel_t            sel_q;
  logic            arm_wr, sel_wr, code_ok;

  assign arm_wr  = wr_en && (wr_data == ARM_WORD);
  assign sel_wr  = wr_en && !wr_data[ARM_BIT] && arm_q;
  assign code_ok = wr_data[SEL_W-1:0] <= TOP_CODE;

  always_ff @(posedge clk) begin
    if (rst) begin
      arm_q <= 1'b0;
      win_q <= '0;
      sel_q <= boot_code(boot_slow);
    end else if (arm_wr) begin
      arm_q <= 1'b1;
      win_q <= WC_W'(WIN);
    end else if (sel_wr) begin
      arm_q <= 1'b0;
      win_q <= '0;
      if (code_ok) sel_q <= wr_data[SEL_W-1:0];
    end else if (arm_q) begin
      if (win_q == WC_W'(1)) begin
        arm_q <= 1'b0;
        win_q <= '0;
      end else begin
        win_q <= win_q - WC_W'(1);
      end
    end
  end

  assign arm_o = arm_q;
  assign sel_o = sel_q;

  AST_QUIET_WHEN_LOCKED: assert property (@(posedge clk) disable iff (rst)
    !arm_q |=> $stable(sel_q)); // R4
  AST_SEL_NOT_RESERVED: assert property (@(posedge clk) disable iff (rst)
    sel_q <= TOP_CODE); // R5
  AST_ACCEPT_CLOSES: assert property (@(posedge clk) disable iff (rst)
    (arm_q && wr_en && !wr_data[ARM_BIT]) |=> !arm_q); // R6
  AST_WINDOW_CLOSES: assert property (@(posedge clk) disable iff (rst)
    (arm_q && win_q == WC_W'(1) && !(wr_en && wr_data == ARM_WORD)) |=> !arm_q); // R3
  AST_ARM_SETS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data == ARM_WORD) |=> (arm_q && $stable(sel_q))); // R2
endmodule

// File: rtl/scp_divcnt.sv
module scp_divcnt
  import scp_pkg::*;
#(
  parameter int MAX_CODE = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic boot_slow,
  input  sel_t sel_i,
  output logic en_o
);
  localparam int CNT_W = (MAX_CODE < 1) ? 1 : MAX_CODE;

  logic [CNT_W-1:0] lim_tab [MAX_CODE+1];
  logic [CNT_W-1:0] cnt_q, cnt_nxt, lim;
  sel_t             act_q;
  logic             en_q, wrap;

  for (genvar g = 0; g <= MAX_CODE; g++) begin : g_lim
    assign lim_tab[g] = CNT_W'((64'd1 << g) - 64'd1);
  end

  always_comb begin
    lim = '0;
    for (int k = 0; k <= MAX_CODE; k++)
      if (act_q == SEL_W'(k)) lim = lim_tab[k];
  end

  assign wrap    = (cnt_q == lim);
  assign cnt_nxt = wrap ? '0 : cnt_q + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      act_q <= boot_code(boot_slow);
      en_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_nxt;
      if (wrap) act_q <= sel_i;
      en_q  <= (cnt_nxt == '0);
    end
  end

  assign en_o = en_q;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= lim); // R8
  AST_ACT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != lim) |=> $stable(act_q)); // R8
  AST_DIV1_STEADY: assert property (@(posedge clk) disable iff (rst)
    (act_q == '0) |-> en_q); // R7
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (en_q && lim != '0) |=> !en_q); // R7
endmodule

// File: rtl/sysclk_prescale_guard.sv
module sysclk_prescale_guard
  import scp_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int WIN      = 4,
  parameter int MAX_CODE = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              boot_slow,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              clk_en
);
  localparam int PAD_W = DATA_W - 1 - SEL_W;

  logic arm;
  sel_t sel;

  scp_unlock #(.DATA_W(DATA_W), .WIN(WIN), .MAX_CODE(MAX_CODE)) u_unlock (
    .clk(clk), .rst(rst), .boot_slow(boot_slow),
    .wr_en(wr_en), .wr_data(wr_data),
    .arm_o(arm), .sel_o(sel)
  );

  scp_divcnt #(.MAX_CODE(MAX_CODE)) u_div (
    .clk(clk), .rst(rst), .boot_slow(boot_slow),
    .sel_i(sel), .en_o(clk_en)
  );

  assign rd_data = {arm, {PAD_W{1'b0}}, sel};
endmodule

// File: tb/sim_sysclk_prescale_guard.sv
module sim_sysclk_prescale_guard;
  timeunit 1ns; timeprecision 1ps;

  logic       clk = 1'b0, rst = 1'b1, boot_slow = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       clk_en;

  sysclk_prescale_guard u0 (
    .clk(clk), .rst(rst), .boot_slow(boot_slow), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .clk_en(clk_en)
  );

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit m_arm = 0;
  int m_left = 0, m_sel = 0;
  bit mon_on = 0, gap_valid = 0;
  int gap = 0;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_rd();
    return (int'(m_arm) << 7) | m_sel;
  endfunction

  // register model built from the requirements
  task automatic model_step(bit we, logic [7:0] d);
    if (we && d == 8'h80) begin
      m_arm = 1; m_left = 4;
    end else if (we && !d[7] && m_arm) begin
      m_arm = 0;
      if (d[3:0] <= 4'd8) m_sel = int'(d[3:0]);
    end else if (m_arm) begin
      m_left--;
      if (m_left == 0) m_arm = 0;
    end
  endtask

  task automatic tick(bit we, logic [7:0] d, string req);
    wr_en = we; wr_data = d;
    @(posedge clk);
    model_step(we, d);
    @(negedge clk);
    wr_en = 1'b0;
    chk(req, int'(rd_data), exp_rd());
  endtask

  task automatic do_reset(bit slow);
    mon_on = 0;
    boot_slow = slow; rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_arm = 0; m_sel = slow ? 3 : 0;
    @(negedge clk);
    chk("R1", int'(rd_data), exp_rd());
  endtask

  task automatic measure(output int p);
    int guard = 0;
    while (!clk_en && guard < 1000) begin @(negedge clk); guard++; end
    p = 0;
    do begin @(negedge clk); p++; end while (!clk_en && p < 1000);
  endtask

  task automatic period_is(int code, string req);
    int p;
    measure(p);
    measure(p);
    chk(req, p, 1 << code);
  endtask

  // R8: every pulse interval must be a legal factor
  always @(negedge clk) begin
    if (mon_on && !rst) begin
      gap++;
      if (clk_en) begin
        if (gap_valid)
          chk("R8", int'(gap >= 1 && gap <= 256 && (gap & (gap - 1)) == 0), 1);
        gap_valid = 1;
        gap = 0;
      end
    end else begin
      gap_valid = 0;
      gap = 0;
    end
  end

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    @(negedge clk);
    do_reset(1);
    mon_on = 1;
    period_is(3, "R1");

    tick(1, 8'h80, "R2");
    tick(1, 8'h06, "R6");
    period_is(6, "R7");
    tick(1, 8'hC0, "R2");
    tick(1, 8'h02, "R4");

    tick(1, 8'h80, "R3");
    repeat (3) tick(0, 8'h00, "R3");
    tick(1, 8'h01, "R3");
    tick(1, 8'h80, "R3");
    repeat (4) tick(0, 8'h00, "R3");
    tick(1, 8'h02, "R3");

    tick(1, 8'h80, "R5");
    tick(1, 8'h0C, "R5");
    tick(1, 8'h03, "R5");

    tick(1, 8'h80, "R10");
    repeat (3) tick(0, 8'h00, "R10");
    tick(1, 8'h80, "R10");
    repeat (3) tick(0, 8'h00, "R10");
    tick(1, 8'h00, "R10");

    tick(1, 8'h80, "R9");
    tick(1, 8'h72, "R9");
    chk("R9", int'(rd_data[6:4]), 0);

    for (int c = 0; c <= 8; c++) begin
      tick(1, 8'h80, "R7");
      tick(1, 8'(c), "R7");
      period_is(c, "R7");
    end

    do_reset(0);
    mon_on = 1;
    period_is(0, "R1");
    tick(1, 8'h80, "R6");
    tick(1, 8'h05, "R6");
    period_is(5, "R6");

    for (int i = 0; i < 3000; i++) begin
      int r;
      r = int'($urandom % 8);
      if (r < 2)      tick(1, 8'h80, "R4");
      else if (r == 2) tick(1, 8'h80 | 8'($urandom % 128), "R2");
      else if (r < 6) tick(1, 8'($urandom % 16), "R4");
      else            tick(0, 8'h00, "R4");
    end
    period_is(m_sel, "R7");

    mon_on = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule